// File: doc/BRIEF.md
# Serial Port Register Block with Receive Queue

This block is the register side of a serial port on a 32-bit single-cycle register bus with a 4 KB window. Software writes the data register to send a byte. The byte leaves on a transmit strobe in the next cycle, with no queue in between. Received characters arrive on a valid/ready byte stream and enter a 16-entry receive queue. Software drains the queue by reading the data register. A separate break strobe stores a flagged entry in the same queue. Baud divisors, line control, control and DMA control are plain storage. The shifter, the baud generator, loopback and DMA are outside this block.

Two interrupt sources, transmit and receive, are latched in a raw status register. Each can be cleared by writing a one to its bit in the clear register. The raw status is gated by a mask, and a single interrupt pin shows whether any enabled source is pending. A read-only window at the top of the address space returns eight identification bytes. The receive stream follows the usual valid/ready rule: a byte is taken on a cycle where both `rx_valid` and `rx_ready` are high. The sender must hold the byte until then. `rx_ready` is low when the queue has no room and in any cycle where `brk_strobe` is high. The transmit strobe has no back-pressure.

Top module: `sctl_uart_regs`

## Requirements
- R1: After reset the flag word (index 6) reads 0x90, level select (index 13) reads 0x12, control (index 12) reads 0x300, mask and raw status read 0, `irq` is low and `rx_ready` is high.
- R2: Storage registers read back the written value truncated to their width, with upper bits reading zero. Widths by word index: 8 is 8 bits, 9 is 16, 10 is 6, 11 is 8, 12 is 16, 13 is 6, 14 is 11, 18 is 3.
- R3: A write to word 0 raises `tx_valid` for one cycle in the next cycle, with `tx_data` equal to the written bits 7:0. It also sets raw status bit 5.
- R4: When line-control bit 4 is 1 the queue takes up to 16 entries. When it is 0 the queue takes one. `rx_ready` is low whenever the queue is at that limit.
- R5: A read of word 0 returns the oldest entry, with the data byte in bits 7:0 and the break mark in bit 10, and removes it. A read while the queue is empty returns the slot at the read position and changes nothing.
- R6: A `brk_strobe` with room in the queue stores 0x400. It takes precedence over `rx_valid`, which is not accepted in that cycle.
- R7: Flag bit 7 is always 1 and bit 5 always 0. Bit 4 is 1 exactly when the queue is empty. Bit 6 sets on a push that fills the queue, or on any push while control bit 4 is 1, and clears on a data read. Writes to the flag word are ignored.
- R8: Raw bit 4 sets when a push brings the entry count to the trigger level of 1. It clears when a data read leaves the count at 0.
- R9: Writing word 17 clears every raw status bit that is 1 in the written value. A source setting its bit in the same cycle wins.
- R10: `irq` is high exactly when raw status AND mask is nonzero, from the cycle after the write that changes either. Word 16 reads that AND.
- R11: Reads of byte offsets 0xFE0 to 0xFFC return byte (offset - 0xFE0)/4 of the identification table. Other unmapped offsets read 0, and writes to them have no effect.
- R12: `bus_rdata` is loaded at the clock edge where `bus_rd` is sampled high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive queue can take a byte |
| rx_data | input | 8 | Receive byte |
| brk_strobe | input | 1 | Line break seen |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Combined interrupt |

## Verification
The checks assume the bus never asserts a write and a read in the same cycle. They also assume `rx_valid` is held only while the sender keeps its byte stable. The stimulus applies one bus operation per task with an idle cycle after it, and drops `rx_valid` after a single cycle whether or not the byte was taken. Cases where the bench expects a byte to be refused are followed by a queue read that shows the byte did not land. The one deliberate overlap, a receive push in the same cycle as a clear write, is built with a fork so that both land on the same edge.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int WIDX_W = 10;

  localparam logic [WIDX_W-1:0] W_DATA  = 10'd0;
  localparam logic [WIDX_W-1:0] W_FLAG  = 10'd6;
  localparam logic [WIDX_W-1:0] W_LPDIV = 10'd8;
  localparam logic [WIDX_W-1:0] W_IDIV  = 10'd9;
  localparam logic [WIDX_W-1:0] W_FDIV  = 10'd10;
  localparam logic [WIDX_W-1:0] W_LINE  = 10'd11;
  localparam logic [WIDX_W-1:0] W_CTRL  = 10'd12;
  localparam logic [WIDX_W-1:0] W_LVL   = 10'd13;
  localparam logic [WIDX_W-1:0] W_MASK  = 10'd14;
  localparam logic [WIDX_W-1:0] W_RAW   = 10'd15;
  localparam logic [WIDX_W-1:0] W_MIS   = 10'd16;
  localparam logic [WIDX_W-1:0] W_CLR   = 10'd17;
  localparam logic [WIDX_W-1:0] W_DMA   = 10'd18;
  localparam logic [6:0]        ID_WIN  = 7'h7F;

  localparam int LPDIV_W = 8;
  localparam int IDIV_W  = 16;
  localparam int FDIV_W  = 6;
  localparam int LINE_W  = 8;
  localparam int CTRL_W  = 16;
  localparam int LVL_W   = 6;
  localparam int IRQ_W   = 11;
  localparam int DMA_W   = 3;

  localparam int IRQ_RX = 4;
  localparam int IRQ_TX = 5;
  localparam int LINE_QUEUE_BIT = 4;
  localparam int CTRL_FULL_BIT  = 4;

  localparam logic [CTRL_W-1:0] CTRL_RST = 16'h0300;
  localparam logic [LVL_W-1:0]  LVL_RST  = 6'h12;

  typedef struct packed {
    logic       brk;
    logic [1:0] pad;
    logic [7:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/sctl_rx_fifo.sv
module sctl_rx_fifo #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 11,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_entry,
  input  logic               pop,
  output logic [ENTRY_W-1:0] head,
  output logic [CNT_W-1:0]   count
);
  logic [ENTRY_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]   rptr;
  logic [PTR_W-1:0]   wptr;
  logic               take;

  // write position is read position plus occupancy, wrapping at DEPTH
  assign wptr = rptr + count[PTR_W-1:0];
  assign take = pop && (count != '0);
  assign head = slot[rptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[i] <= '0;
      else if (push && (wptr == PTR_W'(i)))
        slot[i] <= push_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      count <= '0;
    end else begin
      if (take) rptr <= rptr + 1'b1;
      case ({push, take})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sctl_irq_ctrl.sv
module sctl_irq_ctrl #(
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] hw_set,
  input  logic [IW-1:0] hw_clr,
  input  logic          sw_clr_wr,
  input  logic [IW-1:0] sw_clr_val,
  input  logic          mask_wr,
  input  logic [IW-1:0] mask_val,
  output logic [IW-1:0] raw,
  output logic [IW-1:0] mask,
  output logic [IW-1:0] mis,
  output logic          irq
);
  logic [IW-1:0] drop;

  assign drop = hw_clr | (sw_clr_wr ? sw_clr_val : '0);
  assign mis  = raw & mask;
  assign irq  = |mis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw <= (raw & ~drop) | hw_set;
      if (mask_wr) mask <= mask_val;
    end
  end
endmodule

// File: rtl/sctl_id_rom.sv
module sctl_id_rom #(
  parameter int           NBYTES = 8,
  parameter logic [63:0]  TABLE  = 64'hB105_F00D_0014_1011,
  localparam int          SEL_W  = $clog2(NBYTES)
) (
  input  logic [SEL_W-1:0] sel,
  output logic [7:0]       byte_out
);
  logic [7:0] bytes [NBYTES];

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign bytes[k] = TABLE[8*k +: 8];
  end

  assign byte_out = bytes[sel];
endmodule

// File: rtl/sctl_uart_regs.sv
module sctl_uart_regs
  import sctl_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          RX_TRIG  = 1,
  parameter logic [63:0] ID_TABLE = 64'hB105_F00D_0014_1011,
  localparam int         CNT_W    = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        brk_strobe,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        irq
);
  localparam logic [CNT_W:0] TRIG_V  = (CNT_W+1)'(RX_TRIG);
  localparam logic [CNT_W:0] DEPTH_V = (CNT_W+1)'(DEPTH);

  logic [WIDX_W-1:0] widx;
  logic              id_hit;
  logic              rd_pop;

  logic [LPDIV_W-1:0] lpdiv_q;
  logic [IDIV_W-1:0]  idiv_q;
  logic [FDIV_W-1:0]  fdiv_q;
  logic [LINE_W-1:0]  line_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [DMA_W-1:0]   dma_q;
  logic               full_q;

  logic [CNT_W-1:0]   rx_count;
  logic [CNT_W:0]     cap;
  logic [CNT_W:0]     cnt_after;
  logic               room;
  logic               brk_push;
  logic               rx_push;
  logic               q_push;
  rx_entry_t          in_entry;
  rx_entry_t          head_entry;
  logic [ENTRY_W-1:0] head_bits;

  logic [IRQ_W-1:0]   hw_set;
  logic [IRQ_W-1:0]   hw_clr;
  logic [IRQ_W-1:0]   raw_int;
  logic [IRQ_W-1:0]   int_mask;
  logic [IRQ_W-1:0]   int_mis;
  logic [7:0]         id_byte;
  logic [7:0]         flag_byte;
  logic [31:0]        rd_word;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:16]};

  assign widx   = bus_addr[11:2];
  assign id_hit = (widx[9:3] == ID_WIN);
  assign rd_pop = bus_rd && (widx == W_DATA);

  // receive admission
  assign cap      = line_q[LINE_QUEUE_BIT] ? DEPTH_V : (CNT_W+1)'(1);
  assign room     = ({1'b0, rx_count} < cap);
  assign brk_push = brk_strobe && room;
  assign rx_ready = room && !brk_strobe;
  assign rx_push  = rx_valid && rx_ready;
  assign q_push   = brk_push || rx_push;

  always_comb begin
    in_entry      = '0;
    in_entry.brk  = brk_push;
    in_entry.data = brk_push ? 8'h00 : rx_data;
  end

  always_comb begin
    cnt_after = {1'b0, rx_count};
    if (q_push) cnt_after = cnt_after + 1'b1;
    if (rd_pop && (rx_count != '0)) cnt_after = cnt_after - 1'b1;
  end

  sctl_rx_fifo #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (q_push),
    .push_entry (in_entry),
    .pop        (rd_pop),
    .head       (head_bits),
    .count      (rx_count)
  );
  assign head_entry = rx_entry_t'(head_bits);

  // interrupt sources
  always_comb begin
    hw_set = '0;
    hw_clr = '0;
    hw_set[IRQ_TX] = bus_wr && (widx == W_DATA);
    hw_set[IRQ_RX] = q_push && (cnt_after == TRIG_V);
    hw_clr[IRQ_RX] = rd_pop && (cnt_after == TRIG_V - 1'b1);
  end

  sctl_irq_ctrl #(.IW(IRQ_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_set     (hw_set),
    .hw_clr     (hw_clr),
    .sw_clr_wr  (bus_wr && (widx == W_CLR)),
    .sw_clr_val (bus_wdata[IRQ_W-1:0]),
    .mask_wr    (bus_wr && (widx == W_MASK)),
    .mask_val   (bus_wdata[IRQ_W-1:0]),
    .raw        (raw_int),
    .mask       (int_mask),
    .mis        (int_mis),
    .irq        (irq)
  );

  sctl_id_rom #(.NBYTES(8), .TABLE(ID_TABLE)) u_id (
    .sel      (widx[2:0]),
    .byte_out (id_byte)
  );

  // storage registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpdiv_q <= '0;
      idiv_q  <= '0;
      fdiv_q  <= '0;
      line_q  <= '0;
      ctrl_q  <= CTRL_RST;
      lvl_q   <= LVL_RST;
      dma_q   <= '0;
    end else if (bus_wr) begin
      case (widx)
        W_LPDIV: lpdiv_q <= bus_wdata[LPDIV_W-1:0];
        W_IDIV:  idiv_q  <= bus_wdata[IDIV_W-1:0];
        W_FDIV:  fdiv_q  <= bus_wdata[FDIV_W-1:0];
        W_LINE:  line_q  <= bus_wdata[LINE_W-1:0];
        W_CTRL:  ctrl_q  <= bus_wdata[CTRL_W-1:0];
        W_LVL:   lvl_q   <= bus_wdata[LVL_W-1:0];
        W_DMA:   dma_q   <= bus_wdata[DMA_W-1:0];
        default: ;
      endcase
    end
  end

  // receive-full flag: a filling push sets it, a data read clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      full_q <= 1'b0;
    else if (q_push && ((cnt_after == DEPTH_V) || ctrl_q[CTRL_FULL_BIT]))
      full_q <= 1'b1;
    else if (rd_pop)
      full_q <= 1'b0;
  end

  assign flag_byte = {1'b1, full_q, 1'b0, (rx_count == '0), 4'b0000};

  always_comb begin
    rd_word = '0;
    if (id_hit) begin
      rd_word[7:0] = id_byte;
    end else begin
      case (widx)
        W_DATA:  rd_word[ENTRY_W-1:0] = head_entry;
        W_FLAG:  rd_word[7:0]         = flag_byte;
        W_LPDIV: rd_word[LPDIV_W-1:0] = lpdiv_q;
        W_IDIV:  rd_word[IDIV_W-1:0]  = idiv_q;
        W_FDIV:  rd_word[FDIV_W-1:0]  = fdiv_q;
        W_LINE:  rd_word[LINE_W-1:0]  = line_q;
        W_CTRL:  rd_word[CTRL_W-1:0]  = ctrl_q;
        W_LVL:   rd_word[LVL_W-1:0]   = lvl_q;
        W_MASK:  rd_word[IRQ_W-1:0]   = int_mask;
        W_RAW:   rd_word[IRQ_W-1:0]   = raw_int;
        W_MIS:   rd_word[IRQ_W-1:0]   = int_mis;
        W_DMA:   rd_word[DMA_W-1:0]   = dma_q;
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      tx_valid <= bus_wr && (widx == W_DATA);
      if (bus_wr && (widx == W_DATA)) tx_data <= bus_wdata[7:0];
    end
  end
endmodule

// File: rtl/sctl_uart_regs_chk.sv
module sctl_uart_regs_chk #(
  parameter int  DEPTH   = 16,
  parameter int  RX_TRIG = 1,
  localparam int CNT_W   = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [11:0]      bus_addr,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic             bus_rd,
  input logic [31:0]      bus_rdata,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             brk_strobe,
  input logic             tx_valid,
  input logic [7:0]       tx_data,
  input logic             irq,
  input logic [CNT_W-1:0] occ,
  input logic [10:0]      raw,
  input logic [10:0]      mask
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] PRE_TRIG = CNT_W'(RX_TRIG - 1);

  assert_occ_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH_C);

  assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == DEPTH_C) |-> !rx_ready);

  assert_brk_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_strobe |-> !rx_ready);

  assert_tx_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[11:2] == 10'd0)
    |=> (tx_valid && tx_data == $past(bus_wdata[7:0]) && raw[5]));

  assert_rx_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && occ == PRE_TRIG && !bus_rd) |=> raw[4]);

  assert_w1c_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[11:2] == 10'd17 && bus_wdata[5]) |=> !raw[5]);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 11'd0) |-> !irq);

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[11:2] == 10'd0 && occ == '0 && !rx_valid && !brk_strobe)
    |=> (occ == '0));
endmodule

bind sctl_uart_regs sctl_uart_regs_chk #(.DEPTH(DEPTH), .RX_TRIG(RX_TRIG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .brk_strobe (brk_strobe),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .irq        (irq),
  .occ        (rx_count),
  .raw        (raw_int),
  .mask       (int_mask)
);

// File: tb/tb_sctl_uart_regs.sv
`timescale 1ns/1ps
module tb_sctl_uart_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        brk_strobe = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [7:0]  tx_exp_q[$];
  logic        mon_pend = 1'b0;

  localparam logic [63:0] ID_TAB = 64'hB105_F00D_0014_1011;

  always #5 clk = ~clk;

  sctl_uart_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .brk_strobe(brk_strobe), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: read data comparison and transmit byte comparison
  always @(posedge clk) mon_pend <= bus_rd;

  always @(negedge clk) begin
    if (mon_pend) begin
      if (rd_exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected read", bus_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = rd_exp_q.pop_front();
        t = rd_tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
    if (rst_n && tx_valid) begin
      if (tx_exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected tx", {24'h0, tx_data}, 32'h0);
      end else begin
        logic [7:0] te;
        te = tx_exp_q.pop_front();
        check(tx_data === te, "R3 tx byte", {24'h0, tx_data}, {24'h0, te});
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (a[11:2] == 10'd0) tx_exp_q.push_back(d[7:0]);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    rd_exp_q.push_back(e);
    rd_tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input bit with_brk);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; brk_strobe = with_brk;
    @(negedge clk);
    rx_valid = 1'b0; brk_strobe = 1'b0;
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(irq === 1'b0, "R1 irq low", {31'h0, irq}, 32'h0);
    check(rx_ready === 1'b1, "R1 rx_ready high", {31'h0, rx_ready}, 32'h1);
    rd(12'h018, 32'h90,  "R1 flags");
    rd(12'h034, 32'h12,  "R1 level select");
    rd(12'h030, 32'h300, "R1 control");
    rd(12'h038, 32'h0,   "R1 mask");
    rd(12'h03C, 32'h0,   "R1 raw");

    // R2 storage widths
    wr(12'h024, 32'hFFFF_ABCD); rd(12'h024, 32'hABCD, "R2 int divisor");
    wr(12'h028, 32'hFF);        rd(12'h028, 32'h3F,   "R2 frac divisor");
    wr(12'h020, 32'h1FF);       rd(12'h020, 32'hFF,   "R2 low-power divisor");
    wr(12'h048, 32'hF);         rd(12'h048, 32'h7,    "R2 dma control");
    wr(12'h034, 32'hFFFF);      rd(12'h034, 32'h3F,   "R2 level select");
    wr(12'h030, 32'hFFFF_FFFF); rd(12'h030, 32'hFFFF, "R2 control");
    wr(12'h030, 32'h300);

    // R7 flag writes ignored; R11 unmapped space and id window
    wr(12'h018, 32'h0);  rd(12'h018, 32'h90, "R7 flag write ignored");
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h008, 32'h0,  "R11 unmapped read");
    rd(12'h03C, 32'h0,  "R11 unmapped write no raw effect");
    rd(12'h018, 32'h90, "R11 unmapped write no flag effect");
    for (int k = 0; k < 8; k++)
      rd(12'hFE0 + 12'(4*k), {24'h0, ID_TAB[8*k +: 8]}, "R11 id byte");

    // R3 transmit, R10 mask, R9 clear
    wr(12'h000, 32'h1A5);
    rd(12'h03C, 32'h20, "R3 raw tx set");
    check(irq === 1'b0, "R10 irq masked", {31'h0, irq}, 32'h0);
    wr(12'h038, 32'h20);
    check(irq === 1'b1, "R10 irq after mask", {31'h0, irq}, 32'h1);
    rd(12'h040, 32'h20, "R10 masked status");
    wr(12'h044, 32'h20);
    check(irq === 1'b0, "R9 irq after clear", {31'h0, irq}, 32'h0);
    rd(12'h03C, 32'h0, "R9 raw after clear");

    // R4 single-entry mode, R5, R8
    push(8'h41, 1'b0);
    check(rx_ready === 1'b0, "R4 single entry full", {31'h0, rx_ready}, 32'h0);
    rd(12'h018, 32'h80, "R7 not empty");
    rd(12'h03C, 32'h10, "R8 raw rx set");
    push(8'h42, 1'b0);
    rd(12'h000, 32'h41, "R5 head entry");
    rd(12'h03C, 32'h0,  "R8 raw rx cleared");
    rd(12'h018, 32'h90, "R4 refused byte not stored");
    rd(12'h000, 32'h0,  "R5 empty read stale slot");
    rd(12'h018, 32'h90, "R5 empty read no change");

    // R4 queue mode, 16 entries, wrap
    wr(12'h02C, 32'h10);
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i), 1'b0);
    check(rx_ready === 1'b0, "R4 queue full", {31'h0, rx_ready}, 32'h0);
    rd(12'h018, 32'hC0, "R7 full flag");
    push(8'hEE, 1'b0);
    rd(12'h000, 32'h10, "R5 order first");
    rd(12'h018, 32'h80, "R7 full cleared by read");
    for (int i = 1; i < 16; i++) rd(12'h000, {24'h0, 8'h10 + 8'(i)}, "R5 order");
    rd(12'h018, 32'h90, "R4 extra byte refused");

    // R6 break beats data
    push(8'h77, 1'b1);
    rd(12'h000, 32'h400, "R6 break entry");
    rd(12'h018, 32'h90,  "R6 data not taken with break");

    // R7 control bit forces full flag
    wr(12'h030, 32'h310);
    push(8'h55, 1'b0);
    rd(12'h018, 32'hC0, "R7 full by control bit");
    rd(12'h000, 32'h55, "R5 data after forced full");
    wr(12'h030, 32'h300);

    // R10/R8 receive interrupt on pin
    wr(12'h038, 32'h10);
    push(8'h66, 1'b0);
    check(irq === 1'b1, "R10 rx irq", {31'h0, irq}, 32'h1);
    rd(12'h000, 32'h66, "R5 rx irq data");
    check(irq === 1'b0, "R8 rx irq drop", {31'h0, irq}, 32'h0);

    // R9 set beats clear in same cycle
    fork
      push(8'h33, 1'b0);
      wr(12'h044, 32'h10);
    join
    rd(12'h03C, 32'h10, "R9 set wins over clear");

    // R12 hold
    rd(12'h000, 32'h33, "R12 read value");
    repeat (3) @(negedge clk);
    check(bus_rdata === 32'h33, "R12 rdata holds", bus_rdata, 32'h33);
    check(tx_exp_q.size() == 0, "R3 tx count", tx_exp_q.size(), 32'h0);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule